// File: doc/BRIEF.md
# Parallel Bit Gather and Scatter Unit

This unit applies a mask to a source operand in one of two ways. In gather mode it collects the source bits that sit under the set bits of the mask and packs them, in their original order, into the low end of the result. In scatter mode it does the reverse. It takes the low-order source bits one at a time and writes each one to the next set position of the mask, working upward from bit 0. A word option restricts either operation to the low 32 bits and sign-extends the 32-bit outcome to the full width.

The datapath is sequential. A start pulse latches the operands. The unit then visits one mask position per clock, from bit 0 upward. It keeps a running count of the set mask bits already seen, and that count gives the packed position on the compact side of the transfer. After one visit per bit, a one-cycle done pulse marks the result as valid. The result stays on the output until the next accepted start. The operand width is a parameter, so the same source serves 64-bit datapaths and small widths that can be swept exhaustively.

Top module: `pbx_unit`

## Requirements
- R1: With `op_i` = 0 (gather), result bit k holds the source bit at the k-th set mask position, counted from bit 0, for k below popcount(mask). Every result bit at or above popcount(mask) is 0.
- R2: With `op_i` = 1 (scatter), the source bit k is written to the k-th set mask position, counted from bit 0. Every result bit where the mask is 0 is 0.
- R3: At a width of 8, gather of source 0xF4 under mask 0x63 yields 0x0C, and scatter of the same pair yields 0x20.
- R4: `start_i` is accepted at a rising edge while `busy_o` is 0. `busy_o` is then 1 in the cycles that follow. `done_o` is 1 for exactly one cycle, after XLEN further rising edges, and `busy_o` is 0 in that cycle.
- R5: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation completes with its own operands and its own timing.
- R6: A mask of all zeros gives a zero result for both operations. A mask of all ones returns the source unchanged for both operations.
- R7: With `word_i` = 1 and XLEN above 32, mask bits 32 and above are treated as 0. Result bits 32 and above are copies of result bit 31.
- R8: After `done_o`, `result_o` holds its value until the next accepted start.
- R9: A gather followed by a scatter under the same mask returns the original source ANDed with the mask.
- R10: After reset, `busy_o`, `done_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled at a rising edge |
| op_i | input | 1 | Operation select: 0 gather, 1 scatter |
| word_i | input | 1 | 1 selects the 32-bit word form |
| src_i | input | XLEN | Source operand |
| mask_i | input | XLEN | Mask operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | XLEN | Result of the last completed operation |

## Verification
Three situations are hard to reach from the ports.

The first is a start request that arrives in the middle of a scan. The bench raises `start_i` partway through a wide operation, with inverted operands and the other operation code. It then confirms two things: the result matches the first request, and done arrives on the original cycle.

The second is the limit of the packed counter. A full mask drives the count right up to the width, so the bench covers it with directed all-ones masks at both widths. It also sweeps every 8-bit mask against several sources.

The third is word mode. Its sign extension only shows when the packed bit 31 is 1 and the upper mask bits are set, so the bench builds such operands on purpose.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

   typedef enum logic {
      PBX_GATHER  = 1'b0,
      PBX_SCATTER = 1'b1
   } pbx_op_e;

   localparam int unsigned PBX_WORD_W = 32;

endpackage

// File: rtl/pbx_sequencer.sv
module pbx_sequencer #(
   parameter int unsigned XLEN = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   output logic                     accept_o,
   output logic                     busy_o,
   output logic                     done_o,
   output logic [$clog2(XLEN)-1:0]  idx_o
);
   localparam int unsigned IW = $clog2(XLEN);
   localparam logic [IW-1:0] LAST_IDX = IW'(XLEN - 1);

   logic          busy_q;
   logic          done_q;
   logic [IW-1:0] idx_q;
   logic          at_last;

   assign accept_o = start_i && !busy_q;
   assign at_last  = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= busy_q && at_last;
         if (accept_o) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (busy_q) begin
            if (at_last) begin
               busy_q <= 1'b0;
               idx_q  <= '0;
            end else begin
               idx_q  <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign idx_o  = idx_q;

   // R4
   accept_busy_chk : assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> busy_o);

   // R4
   done_single_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   done_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: rtl/pbx_operand_prep.sv
module pbx_operand_prep
   import pbx_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            word_i,
   input  logic [XLEN-1:0] mask_i,
   output logic [XLEN-1:0] mask_o
);
   generate
      if (XLEN > PBX_WORD_W) begin : g_word
         localparam int unsigned HI_W = XLEN - PBX_WORD_W;
         assign mask_o = word_i ? {{HI_W{1'b0}}, mask_i[PBX_WORD_W-1:0]} : mask_i;
      end else begin : g_full
         logic unused_word;
         assign unused_word = word_i;
         assign mask_o      = mask_i;
      end
   endgenerate

endmodule

// File: rtl/pbx_result_fmt.sv
module pbx_result_fmt
   import pbx_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            word_i,
   input  logic [XLEN-1:0] raw_i,
   output logic [XLEN-1:0] result_o
);
   generate
      if (XLEN > PBX_WORD_W) begin : g_sext
         localparam int unsigned HI_W = XLEN - PBX_WORD_W;
         assign result_o = word_i ?
            {{HI_W{raw_i[PBX_WORD_W-1]}}, raw_i[PBX_WORD_W-1:0]} : raw_i;
      end else begin : g_pass
         logic unused_word;
         assign unused_word = word_i;
         assign result_o    = raw_i;
      end
   endgenerate

endmodule

// File: rtl/pbx_scan_engine.sv
module pbx_scan_engine
   import pbx_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic                     busy_i,
   input  logic [$clog2(XLEN)-1:0]  idx_i,
   input  pbx_op_e                  op_i,
   input  logic                     word_i,
   input  logic [XLEN-1:0]          src_i,
   input  logic [XLEN-1:0]          mask_i,
   output pbx_op_e                  op_o,
   output logic                     word_o,
   output logic [XLEN-1:0]          mask_o,
   output logic [XLEN-1:0]          raw_o
);
   localparam int unsigned IW = $clog2(XLEN);
   localparam int unsigned PW = IW + 1;

   logic [XLEN-1:0] src_q;
   logic [XLEN-1:0] mask_q;
   logic [XLEN-1:0] res_q;
   logic [PW-1:0]   pos_q;
   pbx_op_e         op_q;
   logic            word_q;

   logic [IW-1:0]   pos_idx;
   logic [IW-1:0]   dst_idx;
   logic            pick_bit;
   logic            take;

   assign pos_idx = pos_q[IW-1:0];
   assign take    = busy_i && mask_q[idx_i];

   always_comb begin
      if (op_q == PBX_GATHER) begin
         pick_bit = src_q[idx_i];
         dst_idx  = pos_idx;
      end else begin
         pick_bit = src_q[pos_idx];
         dst_idx  = idx_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
         res_q  <= '0;
         pos_q  <= '0;
         op_q   <= PBX_GATHER;
         word_q <= 1'b0;
      end else if (load_i) begin
         src_q  <= src_i;
         mask_q <= mask_i;
         res_q  <= '0;
         pos_q  <= '0;
         op_q   <= op_i;
         word_q <= word_i;
      end else if (take) begin
         res_q[dst_idx] <= pick_bit;
         pos_q          <= pos_q + 1'b1;
      end
   end

   assign op_o   = op_q;
   assign word_o = word_q;
   assign mask_o = mask_q;
   assign raw_o  = res_q;

   // R1
   pos_bound_chk : assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (pos_q <= PW'(idx_i)));

endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
   import pbx_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            op_i,
   input  logic            word_i,
   input  logic [XLEN-1:0] src_i,
   input  logic [XLEN-1:0] mask_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);
   localparam int unsigned IW = $clog2(XLEN);

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("pbx_unit: XLEN must be at least 4");
      end
   endgenerate

   logic            accept;
   logic [IW-1:0]   idx;
   logic [XLEN-1:0] prep_mask;
   pbx_op_e         eng_op;
   logic            eng_word;
   logic [XLEN-1:0] eng_mask;
   logic [XLEN-1:0] eng_raw;

   pbx_sequencer #(.XLEN(XLEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .idx_o    (idx)
   );

   pbx_operand_prep #(.XLEN(XLEN)) u_prep (
      .word_i (word_i),
      .mask_i (mask_i),
      .mask_o (prep_mask)
   );

   pbx_scan_engine #(.XLEN(XLEN)) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .busy_i (busy_o),
      .idx_i  (idx),
      .op_i   (pbx_op_e'(op_i)),
      .word_i (word_i),
      .src_i  (src_i),
      .mask_i (prep_mask),
      .op_o   (eng_op),
      .word_o (eng_word),
      .mask_o (eng_mask),
      .raw_o  (eng_raw)
   );

   pbx_result_fmt #(.XLEN(XLEN)) u_fmt (
      .word_i   (eng_word),
      .raw_i    (eng_raw),
      .result_o (result_o)
   );

   // R1
   gather_packed_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && eng_op == PBX_GATHER) |-> ((eng_raw >> $countones(eng_mask)) == '0));

   // R2
   scatter_offmask_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && eng_op == PBX_SCATTER) |-> ((eng_raw & ~eng_mask) == '0));

   // R5
   busy_start_ignored_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(eng_mask) && $stable(eng_op)));

   // R8
   result_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));

endmodule

// File: tb/pbx_unit_bench.sv
module pbx_unit_bench;

   localparam int unsigned WIDE = 64;
   localparam int unsigned NARROW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            w_start = 1'b0, w_op = 1'b0, w_word = 1'b0;
   logic [WIDE-1:0] w_src = '0, w_mask = '0;
   logic            w_busy, w_done;
   logic [WIDE-1:0] w_res;

   logic              n_start = 1'b0, n_op = 1'b0, n_word = 1'b0;
   logic [NARROW-1:0] n_src = '0, n_mask = '0;
   logic              n_busy, n_done;
   logic [NARROW-1:0] n_res;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   pbx_unit #(.XLEN(WIDE)) u_pbx_unit (
      .clk(clk), .rst_n(rst_n), .start_i(w_start), .op_i(w_op), .word_i(w_word),
      .src_i(w_src), .mask_i(w_mask), .busy_o(w_busy), .done_o(w_done), .result_o(w_res));

   pbx_unit #(.XLEN(NARROW)) u_pbx_unit_n8 (
      .clk(clk), .rst_n(rst_n), .start_i(n_start), .op_i(n_op), .word_i(n_word),
      .src_i(n_src), .mask_i(n_mask), .busy_o(n_busy), .done_o(n_done), .result_o(n_res));

   function automatic logic [63:0] f_gather(logic [63:0] s, logic [63:0] m, int n);
      logic [63:0] r = '0;
      int k = 0;
      for (int i = 0; i < n; i++) begin
         if (m[i]) begin
            r[k] = s[i];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] f_scatter(logic [63:0] s, logic [63:0] m, int n);
      logic [63:0] r = '0;
      int k = 0;
      for (int i = 0; i < n; i++) begin
         if (m[i]) begin
            r[i] = s[k];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] f_model(bit op, bit word, logic [63:0] s,
                                          logic [63:0] m, int n);
      logic [63:0] mm = m;
      logic [63:0] r;
      if (word && n > 32) mm = {32'd0, m[31:0]};
      r = op ? f_scatter(s, mm, n) : f_gather(s, mm, n);
      if (word && n > 32) r = {{32{r[31]}}, r[31:0]};
      return r;
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_wide(bit op, bit word, logic [63:0] s, logic [63:0] m,
                           bit inject, output logic [63:0] r);
      bit early = 1'b0;
      logic [63:0] held;
      @(negedge clk);
      w_op = op; w_word = word; w_src = s; w_mask = m; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      chk(w_busy == 1'b1, "R4 busy after start", 64'(w_busy), 64'd1);
      for (int k = 1; k <= WIDE; k++) begin
         if (inject && k == 10) begin
            w_start = 1'b1; w_op = ~op; w_src = ~s; w_mask = ~m;
         end
         @(negedge clk);
         w_start = 1'b0;
         if (k < WIDE && w_done) early = 1'b1;
      end
      chk(!early && w_done && !w_busy, inject ? "R5 done timing with busy start" : "R4 done timing",
          {62'd0, w_done, w_busy}, 64'd2);
      r = w_res;
      held = w_res;
      @(negedge clk);
      chk(!w_done && w_res == held, "R8 result hold", w_res, held);
   endtask

   task automatic run_narrow(bit op, logic [7:0] s, logic [7:0] m, output logic [7:0] r);
      bit early = 1'b0;
      @(negedge clk);
      n_op = op; n_word = 1'b0; n_src = s; n_mask = m; n_start = 1'b1;
      @(negedge clk);
      n_start = 1'b0;
      for (int k = 1; k <= NARROW; k++) begin
         @(negedge clk);
         if (k < NARROW && n_done) early = 1'b1;
      end
      if (early || !n_done) chk(1'b0, "R4 narrow done timing", 64'(n_done), 64'd1);
      r = n_res;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] r, r2, s, m, e;
      logic [7:0]  nr, nr2;
      logic [7:0]  nsrc [4];
      void'($urandom(32'd2718));

      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!w_busy && !w_done && w_res == '0, "R10 wide reset", w_res, 64'd0);
      chk(!n_busy && !n_done && n_res == '0, "R10 narrow reset", 64'(n_res), 64'd0);
      rst_n = 1'b1;

      // R3 worked examples at 8 bits
      run_narrow(1'b0, 8'hF4, 8'h63, nr);
      chk(nr == 8'h0C, "R3 gather example", 64'(nr), 64'h0C);
      run_narrow(1'b1, 8'hF4, 8'h63, nr);
      chk(nr == 8'h20, "R3 scatter example", 64'(nr), 64'h20);

      // R1 R2 R6 R9 sweep of every 8-bit mask
      nsrc[0] = 8'hFF; nsrc[1] = 8'hA5;
      nsrc[2] = 8'($urandom); nsrc[3] = 8'($urandom);
      for (int mi = 0; mi < 256; mi++) begin
         for (int si = 0; si < 4; si++) begin
            run_narrow(1'b0, nsrc[si], 8'(mi), nr);
            e = f_gather(64'(nsrc[si]), 64'(mi), 8);
            chk(nr == e[7:0], "R1 narrow gather", 64'(nr), e);
            run_narrow(1'b1, nsrc[si], 8'(mi), nr2);
            e = f_scatter(64'(nsrc[si]), 64'(mi), 8);
            chk(nr2 == e[7:0], "R2 narrow scatter", 64'(nr2), e);
            if (mi == 0) chk(nr == 0 && nr2 == 0, "R6 zero mask", 64'(nr | nr2), 64'd0);
            if (mi == 255) chk(nr == nsrc[si] && nr2 == nsrc[si], "R6 full mask",
                               64'(nr2), 64'(nsrc[si]));
            run_narrow(1'b1, nr, 8'(mi), nr2);
            chk(nr2 == (nsrc[si] & 8'(mi)), "R9 narrow round trip", 64'(nr2),
                64'(nsrc[si] & 8'(mi)));
         end
      end

      // R6 wide corner masks
      s = {$urandom, $urandom};
      run_wide(1'b0, 1'b0, s, 64'd0, 1'b0, r);
      chk(r == 0, "R6 wide zero mask gather", r, 64'd0);
      run_wide(1'b1, 1'b0, s, '1, 1'b0, r);
      chk(r == s, "R6 wide full mask scatter", r, s);
      run_wide(1'b0, 1'b0, s, '1, 1'b0, r);
      chk(r == s, "R6 wide full mask gather", r, s);

      // R7 word form: upper mask ignored, bit 31 sign-extended
      s = 64'h1234_5678_8000_0001;
      run_wide(1'b0, 1'b1, s, '1, 1'b0, r);
      chk(r == 64'hFFFF_FFFF_8000_0001, "R7 word gather sign extension", r,
          64'hFFFF_FFFF_8000_0001);
      run_wide(1'b1, 1'b1, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_0000_C000_0000, 1'b0, r);
      chk(r == 64'hFFFF_FFFF_C000_0000, "R7 word scatter", r, 64'hFFFF_FFFF_C000_0000);

      // R5 start while busy is ignored
      s = {$urandom, $urandom}; m = {$urandom, $urandom};
      run_wide(1'b0, 1'b0, s, m, 1'b1, r);
      e = f_model(1'b0, 1'b0, s, m, 64);
      chk(r == e, "R5 busy start ignored", r, e);

      // R1 R2 R7 random wide operands
      for (int t = 0; t < 120; t++) begin
         bit op, wd;
         op = 1'($urandom); wd = (($urandom % 4) == 0);
         s = {$urandom, $urandom};
         m = {$urandom, $urandom} & {$urandom, $urandom} | (($urandom % 2) ? 64'd0 : {$urandom, $urandom});
         run_wide(op, wd, s, m, 1'b0, r);
         e = f_model(op, wd, s, m, 64);
         chk(r == e, op ? (wd ? "R7 R2 word scatter" : "R2 scatter") :
                          (wd ? "R7 R1 word gather" : "R1 gather"), r, e);
      end

      // R9 wide round trip
      for (int t = 0; t < 20; t++) begin
         s = {$urandom, $urandom}; m = {$urandom, $urandom};
         run_wide(1'b0, 1'b0, s, m, 1'b0, r);
         run_wide(1'b1, 1'b0, r, m, 1'b0, r2);
         chk(r2 == (s & m), "R9 wide round trip", r2, s & m);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule